// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

The block gathers a wide vector of level-sensitive interrupt sources and folds them into one request line per group of eight, for a parent interrupt controller to take as cascaded inputs. Sources are numbered from zero across the whole combiner. Source `s` belongs to group `s / 8` and is line `s % 8` of that group. Each group output is the OR of its enabled, active sources. It is combinational from the source pins, so it follows the sources with no register delay.

Software controls the enables through a small register port. Four groups share one 32-bit bank, and banks sit 0x10 bytes apart. Within a bank, one word sets enable bits and one clears them. Only bits written as one take effect, so a caller can change a single source without a read-modify-write. A third word shows the masked pending status. The number of groups is a parameter. Bits and banks beyond that count read as zero and ignore writes.

Top module: `irqc_top`

## Requirements
- R1: While reset is held and after it is released, every enable bit is zero and every `grp_irq` bit is low, so reading any bank's enable word returns 0.
- R2: A write to word offset 0x0 of a bank (address bits [3:2] = 0) sets the enable bits where `wdata` is one, from the next clock on. Bits written as zero keep their value.
- R3: A write to word offset 0x4 of a bank (address bits [3:2] = 1) clears the enable bits where `wdata` is one, from the next clock on. Bits written as zero keep their value.
- R4: Group n lives in bank n/4, and the bank's address is selected by `addr[ADDR_W-1:4]`. Its sources take bank bits [8*(n%4)+7 : 8*(n%4)], so source s sits at bank s/32, bit s%32.
- R5: `grp_irq[n]` is high in the same cycle that any enabled source of group n is high. It is low when none is.
- R6: A read of word offset 0xC (address bits [3:2] = 3) returns, for each bit of the bank, the source level AND its enable.
- R7: A read of offset 0x0 or offset 0x4 returns the bank's current enable mask.
- R8: Three things read as zero, and writes to them change no enable:
  - bank bits of groups at or beyond NUM_GROUPS;
  - banks whose index is at or beyond the bank count;
  - word offset 0x8.
- R9: Read data appears on `rdata` with `rd_valid` high in the cycle after `rd_en` is sampled. `rd_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address: bank in [ADDR_W-1:4], word in [3:2] |
| wdata | input | 32 | Write data, one bit per source of the bank |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| src_in | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| grp_irq | output | NUM_GROUPS | Per-group combined request |

## Verification
The embedded properties check the following on every cycle:
- after a set write, every written-one bit of a live group is enabled;
- after a clear write, every written-one bit is disabled;
- a cycle with no write leaves the enables unchanged;
- a group output never rises without one of its own sources high;
- each read strobe is answered by `rd_valid` one cycle later.

Some behaviours only the bench scenarios can show:
- the address mapping of groups to banks and bit fields;
- the masked status word;
- zero reads of absent groups, banks and the unused offset;
- writes to absent banks leaving the live enables untouched;
- the exact level of each group output as sources and enables change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      WORD_SET  = 2'd0,
      WORD_CLR  = 2'd1,
      WORD_NONE = 2'd2,
      WORD_STAT = 2'd3
   } irqc_word_e;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int GROUP_W     = 8,
   parameter int GPB         = 4,
   parameter int LIVE_GROUPS = 4,
   localparam int W          = GROUP_W * GPB
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] set_mask,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] src,
   output logic [W-1:0] en_q,
   output logic [W-1:0] pend
);
   logic [W-1:0] live;

   for (genvar g = 0; g < GPB; g++) begin : g_live
      if (g < LIVE_GROUPS) begin : g_on
         assign live[g*GROUP_W +: GROUP_W] = '1;
      end else begin : g_off
         assign live[g*GROUP_W +: GROUP_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) en_q <= '0;
      else     en_q <= (en_q | (set_mask & live)) & ~clr_mask;
   end

   assign pend = src & en_q;

   // R2
   a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
      (set_mask != '0) |=> ((en_q & $past(set_mask & live & ~clr_mask))
                            == $past(set_mask & live & ~clr_mask)));
   // R3
   a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (clr_mask != '0) |=> ((en_q & $past(clr_mask)) == '0));
   // R2, R3: zero bits have no effect
   a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
      (set_mask == '0 && clr_mask == '0) |=> $stable(en_q));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_W    = 8,
   parameter int GPB        = 4,
   parameter int ADDR_W     = 8,
   localparam int DATA_W    = GROUP_W * GPB,
   localparam int NSRC      = NUM_GROUPS * GROUP_W,
   localparam int NB        = (NUM_GROUPS + GPB - 1) / GPB,
   localparam int BSEL_W    = ADDR_W - 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              rd_valid,
   input  logic [NSRC-1:0]   src_in,
   output logic [NUM_GROUPS-1:0] grp_irq
);
   if (DATA_W != 32) begin : g_bad_width
      $error("irqc_top: GROUP_W * GPB must equal 32");
   end
   if (ADDR_W <= 4) begin : g_bad_addr
      $error("irqc_top: ADDR_W must exceed 4");
   end
   if (NB > (1 << BSEL_W)) begin : g_bad_banks
      $error("irqc_top: ADDR_W too small for bank count");
   end

   logic [BSEL_W-1:0]    bank_sel;
   irqc_word_e           word;
   logic [NB*DATA_W-1:0] src_pad;
   logic [NB*DATA_W-1:0] en_all;
   logic [NB*DATA_W-1:0] pend_all;
   logic [31:0]          rd_word;

   assign bank_sel = addr[ADDR_W-1:4];
   assign word     = irqc_word_e'(addr[3:2]);
   assign src_pad  = (NB*DATA_W)'(src_in);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam int LIVE = (NUM_GROUPS - b*GPB > GPB) ? GPB : NUM_GROUPS - b*GPB;
      logic hit;
      logic [DATA_W-1:0] set_m, clr_m;
      assign hit   = wr_en && (bank_sel == BSEL_W'(b));
      assign set_m = (hit && word == WORD_SET) ? wdata : '0;
      assign clr_m = (hit && word == WORD_CLR) ? wdata : '0;
      irqc_bank #(.GROUP_W(GROUP_W), .GPB(GPB), .LIVE_GROUPS(LIVE)) u_bank (
         .clk      (clk),
         .rst      (rst),
         .set_mask (set_m),
         .clr_mask (clr_m),
         .src      (src_pad[b*DATA_W +: DATA_W]),
         .en_q     (en_all[b*DATA_W +: DATA_W]),
         .pend     (pend_all[b*DATA_W +: DATA_W])
      );
   end

   always_comb begin
      rd_word = '0;
      for (int b = 0; b < NB; b++) begin
         if (bank_sel == BSEL_W'(b)) begin
            case (word)
               WORD_SET, WORD_CLR: rd_word = en_all[b*DATA_W +: DATA_W];
               WORD_STAT:          rd_word = pend_all[b*DATA_W +: DATA_W];
               default:            rd_word = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_word;
      end
   end

   // R9
   a_r9_read_answer: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rd_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> !rd_valid);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
      assign grp_irq[g] = |pend_all[g*GROUP_W +: GROUP_W];
      // R5: a group output rises only with one of its own sources high
      a_r5_rise_needs_src: assert property (@(posedge clk) disable iff (rst)
         $rose(grp_irq[g]) |-> (|src_in[g*GROUP_W +: GROUP_W]));
   end
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 6;
   localparam int NS = NG * 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic rd_valid;
   logic [NS-1:0] src_in = '0;
   logic [NG-1:0] grp_irq;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irqc_top #(.NUM_GROUPS(NG)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
      .src_in(src_in), .grp_irq(grp_irq)
   );

   task automatic report(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design answers
   always @(negedge clk) begin
      if (!rst && rd_valid) begin
         if (exp_q.size() == 0) begin
            report(1'b0, "R9 unexpected rd_valid", 64'(rdata), 64'(0));
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            report(rdata === e, t, 64'(rdata), 64'(e));
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(t);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic drive_src(input logic [NS-1:0] v);
      @(negedge clk);
      src_in = v;
      #1;
   endtask

   task automatic chk_irq(input logic [NG-1:0] e, input string t);
      report(grp_irq === e, t, 64'(grp_irq), 64'(e));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      report(1'b0, "watchdog expired", 64'(0), 64'(1));
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_irq('0, "R1 irq low in reset");
      rst = 1'b0;
      src_in = '1;
      #1;
      chk_irq('0, "R1 all sources high, no enable");
      rd(8'h00, 32'h0, "R1 bank0 enable after reset");
      rd(8'h10, 32'h0, "R1 bank1 enable after reset");
      src_in = '0;

      wr(8'h00, 32'h0000_0181);
      rd(8'h00, 32'h0000_0181, "R2 R7 set word read");
      rd(8'h04, 32'h0000_0181, "R7 clear word read");
      wr(8'h00, 32'h0);
      rd(8'h00, 32'h0000_0181, "R2 zero write no effect");
      wr(8'h00, 32'h0100_0000);
      rd(8'h00, 32'h0100_0181, "R2 set adds bit, keeps others");

      drive_src(NS'(48'h1));
      chk_irq(6'b000001, "R5 group0 from enabled line0");
      drive_src(NS'(48'h2));
      chk_irq(6'b000000, "R5 disabled line1 ignored");
      drive_src(NS'(48'h0103));
      chk_irq(6'b000011, "R5 groups 0 and 1");
      rd(8'h0C, 32'h0000_0101, "R6 masked status bank0");
      drive_src(NS'(48'h0100_0000));
      chk_irq(6'b001000, "R4 source 24 drives group3");

      wr(8'h04, 32'h0000_0001);
      rd(8'h00, 32'h0100_0180, "R3 clear removes bit0 only");
      drive_src(NS'(48'h1));
      chk_irq(6'b000000, "R3 cleared source no output");
      wr(8'h04, 32'h0);
      rd(8'h04, 32'h0100_0180, "R3 zero clear no effect");

      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, 32'h0000_FFFF, "R8 absent groups read zero");
      drive_src(NS'(48'h0800_0000_0000));
      chk_irq(6'b100000, "R4 source 43 drives group5");
      rd(8'h1C, 32'h0000_0800, "R4 R6 status bank1 bit11");
      drive_src(NS'(48'h0001_0000_0000));
      chk_irq(6'b010000, "R4 source 32 drives group4");
      wr(8'h14, 32'h0000_00FF);
      rd(8'h10, 32'h0000_FF00, "R3 clear group4 in bank1");
      chk_irq(6'b000000, "R5 group4 drops after clear");

      rd(8'h08, 32'h0, "R8 unused word reads zero");
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, 32'h0, "R8 absent bank reads zero");
      rd(8'h00, 32'h0100_0180, "R8 bank0 untouched by absent writes");
      rd(8'h10, 32'h0000_FF00, "R8 bank1 untouched by absent writes");

      repeat (2) @(negedge clk);
      report(exp_q.size() == 0, "R9 every read answered", 64'(exp_q.size()), 64'(0));

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule